// File: doc/BRIEF.md
# Converter Status Flag Register

This block holds the status word of a two-channel converter interface that has a primary and an auxiliary channel. Hardware events come in on pulses: a result written for either channel, with its out-of-range indication, calibration complete, a periodic gross-overrange sample, and two threshold comparator levels. Bus events come in the same way: a write to the mode register, reads of either channel's data register, the level of the gross-overrange enable, and a pulse when the primary gain changes.

Each flag has its own set rule and its own clear rule. The block packs the flags into a 16-bit word that a bus read returns. It also stores each channel's result. An out-of-range result is replaced by the matching full-scale limit before it is stored. The analog converter, the calibration sequencer and the address decoding sit outside this block.

Top module: `adc_status_word`

## Requirements
- R1: After a synchronous reset, the status word, both stored results and the pending auxiliary-read marker are all zero.
- R2: Bit 15 is the calibration-done flag. A calibration-done pulse sets it and a mode-register write clears it. If both happen in the same cycle, the flag ends up set.
- R3: A result flagged overrange is stored as 24'h7FFFFF. A result flagged underrange is stored as 24'h800000, and underrange takes precedence if both flags are raised. An in-range result is stored unchanged as signed 24-bit two's complement.
- R4: Bit 13 is the auxiliary error flag and bit 12 is the primary error flag. An out-of-range result write on a channel sets that channel's flag. The next in-range write on the same channel clears it.
- R5: Bit 0 is primary ready. An in-range primary write or a calibration-done pulse sets it, and a primary data read clears it. A set in the same cycle as the read wins.
- R6: Bit 1 is auxiliary ready. An in-range auxiliary write or a calibration-done pulse sets it. It clears only on a primary read that follows an earlier auxiliary read. A primary read on its own leaves it set, and so does an auxiliary read on its own.
- R7: Bit 2 is gross overrange. It sets on an update tick with the overrange sample high, but only while its enable is high. It stays set until the enable goes low or a gain-change pulse arrives. A set in the same cycle as a gain change wins.
- R8: Bit 4 shows the primary comparator threshold level and bit 6 shows the accumulator threshold level. Each is registered one cycle after its input.
- R9: Bits 3, 5, 7 to 11 and 14 always read as zero.
- R10: An out-of-range write does not set the ready flag of its channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_wr | input | 1 | Primary result write pulse |
| pri_raw | input | 24 | Primary raw result |
| pri_over | input | 1 | Primary result is overrange |
| pri_under | input | 1 | Primary result is underrange |
| aux_wr | input | 1 | Auxiliary result write pulse |
| aux_raw | input | 24 | Auxiliary raw result |
| aux_over | input | 1 | Auxiliary result is overrange |
| aux_under | input | 1 | Auxiliary result is underrange |
| cal_done | input | 1 | Calibration sequence complete pulse |
| gross_tick | input | 1 | Gross-overrange update tick |
| gross_hit | input | 1 | Gross-overrange sample level |
| gross_en | input | 1 | Gross-overrange detect enable |
| gain_chg | input | 1 | Primary gain changed pulse |
| pri_thr | input | 1 | Primary comparator threshold exceeded |
| acc_thr | input | 1 | Accumulator threshold exceeded |
| mode_wr | input | 1 | Mode register write pulse |
| pri_rd | input | 1 | Primary data read pulse |
| aux_rd | input | 1 | Auxiliary data read pulse |
| status | output | 16 | Packed status word |
| pri_data | output | 24 | Stored primary result |
| aux_data | output | 24 | Stored auxiliary result |

## Verification
Two cases can land in one cycle: a hardware set and a software clear of the same flag, and a primary read together with an auxiliary read. The bench forces each pairing on a single clock edge: calibration done with a mode write, a primary write with a primary read, and an update tick with a gain change. It then checks that the flag is still set. A separate test drives the primary and auxiliary reads together and checks that auxiliary ready survives, since the marker was not armed before that read.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
  localparam int STAT_W = 16;
  localparam int B_PRDY = 0;
  localparam int B_ARDY = 1;
  localparam int B_GOVR = 2;
  localparam int B_PTHR = 4;
  localparam int B_ATHR = 6;
  localparam int B_PERR = 12;
  localparam int B_AERR = 13;
  localparam int B_CAL  = 15;
  localparam logic [STAT_W-1:0] RSV_MASK = 16'h4FA8;
endpackage

// File: rtl/adc_result_clamp.sv
module adc_result_clamp #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] raw,
  input  logic          over,
  input  logic          under,
  output logic [DW-1:0] data,
  output logic          good_wr,
  output logic          bad_wr
);
  localparam logic [DW-1:0] POS_FS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_FS = {1'b1, {(DW-1){1'b0}}};

  assign good_wr = wr && !over && !under;
  assign bad_wr  = wr && (over || under);

  always_ff @(posedge clk) begin
    if (rst) data <= '0;
    else if (wr) begin
      if (under)     data <= NEG_FS;
      else if (over) data <= POS_FS;
      else           data <= raw;
    end
  end

  a_r3_over_clamp: assert property (@(posedge clk) disable iff (rst)
    (wr && over && !under) |=> (data == POS_FS));
  a_r3_under_clamp: assert property (@(posedge clk) disable iff (rst)
    (wr && under) |=> (data == NEG_FS));
endmodule

// File: rtl/adc_ready_tracker.sv
module adc_ready_tracker (
  input  logic clk,
  input  logic rst,
  input  logic pri_set,
  input  logic aux_set,
  input  logic pri_rd,
  input  logic aux_rd,
  output logic pri_rdy,
  output logic aux_rdy
);
  logic aux_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_rdy  <= 1'b0;
      aux_rdy  <= 1'b0;
      aux_seen <= 1'b0;
    end else begin
      if (pri_set)     pri_rdy <= 1'b1;
      else if (pri_rd) pri_rdy <= 1'b0;

      if (aux_set)                  aux_rdy <= 1'b1;
      else if (pri_rd && aux_seen)  aux_rdy <= 1'b0;

      if (aux_rd)      aux_seen <= 1'b1;
      else if (pri_rd) aux_seen <= 1'b0;
    end
  end

  a_r6_no_clear_unarmed: assert property (@(posedge clk) disable iff (rst)
    (aux_rdy && !aux_seen) |=> aux_rdy);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (pri_rd && !pri_set) |=> !pri_rdy);
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    pri_set |=> pri_rdy);
endmodule

// File: rtl/adc_status_word.sv
module adc_status_word #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pri_wr,
  input  logic [DW-1:0] pri_raw,
  input  logic          pri_over,
  input  logic          pri_under,
  input  logic          aux_wr,
  input  logic [DW-1:0] aux_raw,
  input  logic          aux_over,
  input  logic          aux_under,
  input  logic          cal_done,
  input  logic          gross_tick,
  input  logic          gross_hit,
  input  logic          gross_en,
  input  logic          gain_chg,
  input  logic          pri_thr,
  input  logic          acc_thr,
  input  logic          mode_wr,
  input  logic          pri_rd,
  input  logic          aux_rd,
  output logic [15:0]   status,
  output logic [DW-1:0] pri_data,
  output logic [DW-1:0] aux_data
);
  import adc_stat_pkg::*;

  logic pri_good, pri_bad, aux_good, aux_bad;
  logic pri_rdy, aux_rdy;
  logic cal_f, perr_f, aerr_f, govr_f, pthr_f, athr_f;
  logic govr_set;

  adc_result_clamp #(.DW(DW)) u_pclamp (
    .clk(clk), .rst(rst), .wr(pri_wr), .raw(pri_raw), .over(pri_over),
    .under(pri_under), .data(pri_data), .good_wr(pri_good), .bad_wr(pri_bad));

  adc_result_clamp #(.DW(DW)) u_aclamp (
    .clk(clk), .rst(rst), .wr(aux_wr), .raw(aux_raw), .over(aux_over),
    .under(aux_under), .data(aux_data), .good_wr(aux_good), .bad_wr(aux_bad));

  adc_ready_tracker u_rdy (
    .clk(clk), .rst(rst), .pri_set(pri_good || cal_done),
    .aux_set(aux_good || cal_done), .pri_rd(pri_rd), .aux_rd(aux_rd),
    .pri_rdy(pri_rdy), .aux_rdy(aux_rdy));

  assign govr_set = gross_en && gross_tick && gross_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_f  <= 1'b0;
      perr_f <= 1'b0;
      aerr_f <= 1'b0;
      govr_f <= 1'b0;
      pthr_f <= 1'b0;
      athr_f <= 1'b0;
    end else begin
      if (cal_done)     cal_f <= 1'b1;
      else if (mode_wr) cal_f <= 1'b0;

      if (pri_bad)       perr_f <= 1'b1;
      else if (pri_good) perr_f <= 1'b0;

      if (aux_bad)       aerr_f <= 1'b1;
      else if (aux_good) aerr_f <= 1'b0;

      if (govr_set)                  govr_f <= 1'b1;
      else if (!gross_en || gain_chg) govr_f <= 1'b0;

      pthr_f <= pri_thr;
      athr_f <= acc_thr;
    end
  end

  always_comb begin
    status         = '0;
    status[B_PRDY] = pri_rdy;
    status[B_ARDY] = aux_rdy;
    status[B_GOVR] = govr_f;
    status[B_PTHR] = pthr_f;
    status[B_ATHR] = athr_f;
    status[B_PERR] = perr_f;
    status[B_AERR] = aerr_f;
    status[B_CAL]  = cal_f;
  end

  a_r2_mode_clears: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && !cal_done) |=> !status[B_CAL]);
  a_r2_cal_sets: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> status[B_CAL]);
  a_r7_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !gross_en |=> !status[B_GOVR]);
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (status[B_GOVR] && gross_en && !gain_chg) |=> status[B_GOVR]);
  a_r4_pri_err_set: assert property (@(posedge clk) disable iff (rst)
    (pri_wr && (pri_over || pri_under)) |=> status[B_PERR]);
  a_r9_reserved: assert property (@(posedge clk) disable iff (rst)
    (status & RSV_MASK) == 16'h0);
endmodule

// File: tb/adc_status_word_bench.sv
module adc_status_word_bench;
  logic clk = 1'b0;
  logic rst;
  logic pri_wr, pri_over, pri_under, aux_wr, aux_over, aux_under;
  logic [23:0] pri_raw, aux_raw;
  logic cal_done, gross_tick, gross_hit, gross_en, gain_chg;
  logic pri_thr, acc_thr, mode_wr, pri_rd, aux_rd;
  logic [15:0] status;
  logic [23:0] pri_data, aux_data;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_status_word u_adc_status_word (
    .clk(clk), .rst(rst), .pri_wr(pri_wr), .pri_raw(pri_raw),
    .pri_over(pri_over), .pri_under(pri_under), .aux_wr(aux_wr),
    .aux_raw(aux_raw), .aux_over(aux_over), .aux_under(aux_under),
    .cal_done(cal_done), .gross_tick(gross_tick), .gross_hit(gross_hit),
    .gross_en(gross_en), .gain_chg(gain_chg), .pri_thr(pri_thr),
    .acc_thr(acc_thr), .mode_wr(mode_wr), .pri_rd(pri_rd), .aux_rd(aux_rd),
    .status(status), .pri_data(pri_data), .aux_data(aux_data));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_pulses();
    pri_wr = 0; pri_over = 0; pri_under = 0; aux_wr = 0; aux_over = 0;
    aux_under = 0; cal_done = 0; gross_tick = 0; gross_hit = 0;
    gain_chg = 0; mode_wr = 0; pri_rd = 0; aux_rd = 0;
  endtask

  task automatic step();
    @(negedge clk);
    clr_pulses();
  endtask

  task automatic t_reset();
    rst = 1; clr_pulses(); gross_en = 0; pri_thr = 0; acc_thr = 0;
    pri_raw = 24'h0; aux_raw = 24'h0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    check("R1 status", {16'h0, status}, 32'h0);
    check("R1 pri_data", {8'h0, pri_data}, 32'h0);
    check("R1 aux_data", {8'h0, aux_data}, 32'h0);
  endtask

  task automatic t_cal();
    cal_done = 1; step();
    check("R2 cal set", {31'h0, status[15]}, 32'h1);
    check("R5 cal sets pri ready", {31'h0, status[0]}, 32'h1);
    check("R6 cal sets aux ready", {31'h0, status[1]}, 32'h1);
    mode_wr = 1; step();
    check("R2 mode write clears", {31'h0, status[15]}, 32'h0);
    cal_done = 1; mode_wr = 1; step();
    check("R2 set wins over mode write", {31'h0, status[15]}, 32'h1);
    mode_wr = 1; step();
    aux_rd = 1; step(); pri_rd = 1; step();
    check("R6 cleared after cal", {30'h0, status[1:0]}, 32'h0);
  endtask

  task automatic t_clamp_err();
    pri_wr = 1; pri_raw = 24'h123456; pri_over = 1; step();
    check("R3 over clamp", {8'h0, pri_data}, 32'h007FFFFF);
    check("R4 pri err set", {31'h0, status[12]}, 32'h1);
    check("R10 no ready on bad write", {31'h0, status[0]}, 32'h0);
    aux_wr = 1; aux_raw = 24'h000010; aux_under = 1; step();
    check("R3 under clamp", {8'h0, aux_data}, 32'h00800000);
    check("R4 aux err set", {31'h0, status[13]}, 32'h1);
    check("R10 no aux ready on bad write", {31'h0, status[1]}, 32'h0);
    aux_wr = 1; aux_over = 1; aux_under = 1; step();
    check("R3 under wins", {8'h0, aux_data}, 32'h00800000);
    pri_wr = 1; pri_raw = 24'hFFFF00; step();
    check("R3 in-range stored", {8'h0, pri_data}, 32'h00FFFF00);
    check("R4 pri err cleared", {31'h0, status[12]}, 32'h0);
    check("R4 aux err untouched", {31'h0, status[13]}, 32'h1);
    aux_wr = 1; aux_raw = 24'h000042; step();
    check("R4 aux err cleared", {31'h0, status[13]}, 32'h0);
    check("R3 aux in-range", {8'h0, aux_data}, 32'h00000042);
  endtask

  task automatic t_ready();
    pri_rd = 1; step();
    check("R5 pri read clears", {31'h0, status[0]}, 32'h0);
    check("R6 pri read alone keeps aux", {31'h0, status[1]}, 32'h1);
    aux_rd = 1; step();
    check("R6 aux read alone keeps aux", {31'h0, status[1]}, 32'h1);
    pri_rd = 1; step();
    check("R6 aux then pri clears", {31'h0, status[1]}, 32'h0);
    aux_wr = 1; aux_raw = 24'h1; step();
    aux_rd = 1; pri_rd = 1; step();
    check("R6 same-cycle reads keep aux", {31'h0, status[1]}, 32'h1);
    pri_rd = 1; step();
    check("R6 marker armed then consumed", {31'h0, status[1]}, 32'h0);
    pri_wr = 1; pri_raw = 24'h7; pri_rd = 1; step();
    check("R5 set wins over read", {31'h0, status[0]}, 32'h1);
  endtask

  task automatic t_gross();
    gross_en = 0; gross_tick = 1; gross_hit = 1; step();
    check("R7 disabled no set", {31'h0, status[2]}, 32'h0);
    gross_en = 1; gross_tick = 1; gross_hit = 0; step();
    check("R7 tick without hit", {31'h0, status[2]}, 32'h0);
    gross_hit = 1; step();
    check("R7 no tick no set", {31'h0, status[2]}, 32'h0);
    gross_tick = 1; gross_hit = 1; step();
    check("R7 set", {31'h0, status[2]}, 32'h1);
    gross_tick = 1; gross_hit = 0; step(); step();
    check("R7 sticky", {31'h0, status[2]}, 32'h1);
    gain_chg = 1; step();
    check("R7 gain change clears", {31'h0, status[2]}, 32'h0);
    gross_tick = 1; gross_hit = 1; gain_chg = 1; step();
    check("R7 set wins over gain change", {31'h0, status[2]}, 32'h1);
    gross_en = 0; step();
    check("R7 disable clears", {31'h0, status[2]}, 32'h0);
  endtask

  task automatic t_thresh();
    pri_thr = 1; acc_thr = 0; step();
    check("R8 pri thr", {30'h0, status[6], status[4]}, 32'h1);
    pri_thr = 0; acc_thr = 1; step();
    check("R8 acc thr", {30'h0, status[6], status[4]}, 32'h2);
    acc_thr = 0; cal_done = 1; pri_wr = 1; pri_over = 1; aux_wr = 1;
    aux_under = 1; gross_en = 1; gross_tick = 1; gross_hit = 1;
    pri_thr = 1; acc_thr = 1; step();
    check("R9 reserved zero with all set", {16'h0, status & 16'h4FA8}, 32'h0);
    check("R9 live bits", {16'h0, status}, 32'h0000B057);
  endtask

  initial begin
    t_reset();
    t_cal();
    t_clamp_err();
    t_ready();
    t_gross();
    t_thresh();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule